// File: doc/BRIEF.md
# External CAM lookup sequencer

This block resolves the address of a received frame against an external content-addressable memory (CAM). A frame-side agent offers a 64-bit lookup key on a valid/ready request port. The sequencer then runs a fixed bus ritual on a simple 32-bit CAM bus:

- a write carrying the upper key half;
- a write carrying the lower key half;
- one read that returns the verdict.

A set top bit in the verdict marks the frame for rejection. Otherwise the low sixteen bits become a tag that the frame path appends after the frame's last byte.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a requester holding `req_valid` high during a lookup is simply stalled. The key need only be stable in the accepting cycle, because it is registered there. The result side is a plain set of status pins qualified by a one-cycle `res_done` strobe. The CAM bus has no back-pressure of its own beyond `cam_ack`: each access stays on the bus until acknowledged.

A mode pin selects whether lookups happen at all. With it low, an accepted request completes at once, without bus traffic and without a tag. An acknowledge watchdog (`ACK_TIMEOUT` cycles per access; 0 disables it) turns a silent CAM into a rejected frame rather than a hung receiver.

Top module: `cam_lookup_seq`

## Requirements
- R1: With `promisc_en` high at acceptance, the bus shows exactly three accesses in order: a write with `cam_wdata` = key[63:32], a write with `cam_wdata` = key[31:0], then a read; `cam_wr` and `cam_rd` are never high together.
- R2: Each access holds its strobe and `cam_wdata` unchanged until a cycle with `cam_ack` high; the next access (or the result) appears in the cycle right after that acknowledge.
- R3: If bit 31 of `cam_rdata` at the read acknowledge is 1, the result shows `res_reject` = 1, `res_tag_vld` = 0 and `res_tag` = 0.
- R4: If bit 31 of `cam_rdata` at the read acknowledge is 0, the result shows `res_reject` = 0, `res_tag_vld` = 1 and `res_tag` = `cam_rdata[15:0]`.
- R5: `res_done` is high for exactly one cycle, the cycle after the read acknowledge (or after a bypass acceptance or a timeout). The result pins then hold until the next accepted request clears them to zero.
- R6: With `promisc_en` low at acceptance, no CAM access is made; `res_done` pulses in the cycle after acceptance with `res_reject` = 0 and `res_tag_vld` = 0.
- R7: `req_ready` is high only when idle; requests offered during a lookup and `cam_ack` pulses while idle have no effect.
- R8: If an access sees no `cam_ack` in its first `ACK_TIMEOUT` cycles, the sequence aborts. `res_done` pulses in the next cycle with `res_reject` = 1, `res_timeout` = 1 and `res_tag_vld` = 0, and the block returns to idle. An acknowledge in the last allowed cycle still counts.
- R9: During and right after reset: `req_ready` = 1, no bus strobe, and `res_done`, `res_reject`, `res_tag_vld`, `res_tag` and `res_timeout` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| promisc_en | input | 1 | Lookup mode: 1 runs the CAM sequence, 0 bypasses it |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_key | input | 64 | Lookup key |
| cam_wr | output | 1 | CAM write strobe, held until acknowledged |
| cam_rd | output | 1 | CAM read strobe, held until acknowledged |
| cam_wdata | output | 32 | CAM write data |
| cam_rdata | input | 32 | CAM read data, sampled at the read acknowledge |
| cam_ack | input | 1 | CAM access acknowledge |
| res_done | output | 1 | One-cycle result strobe |
| res_reject | output | 1 | Frame is to be dropped |
| res_tag_vld | output | 1 | `res_tag` is to be appended to the frame |
| res_tag | output | 16 | Tag from the CAM verdict |
| res_timeout | output | 1 | The result came from an acknowledge timeout |

## Verification
The sequence is tried with acknowledges that come at once, after a few cycles, and in the last cycle the watchdog allows. This separates correct per-access holding from an off-by-one in the timeout window. Verdicts with the top bit set and clear, each with noisy middle bits, show whether the decision and the tag extraction use the right bit positions. Timeouts on the first write and on the read show the abort works from any access. A bypassed request, requests held high through a busy lookup, and acknowledges pulsed while idle show that nothing reaches the bus or the result outside a genuine lookup.

// File: rtl/cam_lookup_pkg.sv
package cam_lookup_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WR_HI = 3'd1,
    PH_WR_LO = 3'd2,
    PH_RD    = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

endpackage

// File: rtl/cam_seq_fsm.sv
module cam_seq_fsm
  import cam_lookup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   promisc_en,
  input  logic   beat_ack,
  input  logic   beat_expire,
  output phase_t phase,
  output logic   req_ready,
  output logic   req_fire,
  output logic   res_done
);

  phase_t phase_nx;

  assign req_ready = (phase == PH_IDLE);
  assign req_fire  = req_ready && req_valid;
  assign res_done  = (phase == PH_DONE);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: begin
        if (req_valid) phase_nx = promisc_en ? PH_WR_HI : PH_DONE;
      end
      PH_WR_HI: begin
        if (beat_ack)         phase_nx = PH_WR_LO;
        else if (beat_expire) phase_nx = PH_DONE;
      end
      PH_WR_LO: begin
        if (beat_ack)         phase_nx = PH_RD;
        else if (beat_expire) phase_nx = PH_DONE;
      end
      PH_RD: begin
        if (beat_ack || beat_expire) phase_nx = PH_DONE;
      end
      PH_DONE:  phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R5: the result strobe never lasts two cycles
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R6: a bypassed request finishes in the following cycle
  a_r6_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !promisc_en) |=> res_done);

  // R8: watchdog expiry aborts to the result cycle
  a_r8_expire_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    beat_expire |=> (res_done && $past(phase) != PH_IDLE));

endmodule

// File: rtl/cam_bus_master.sv
module cam_bus_master
  import cam_lookup_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ACK_TIMEOUT = 16,
  localparam int KEY_W      = 2 * BUS_W,
  localparam int CNT_W      = $clog2(ACK_TIMEOUT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic             req_fire,
  input  logic [KEY_W-1:0] req_key,
  input  logic             cam_ack,
  output logic             cam_wr,
  output logic             cam_rd,
  output logic [BUS_W-1:0] cam_wdata,
  output logic             beat_ack,
  output logic             beat_expire
);

  logic [KEY_W-1:0] key_q;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (req_fire) key_q <= req_key;
  end

  assign cam_wr   = (phase == PH_WR_HI) || (phase == PH_WR_LO);
  assign cam_rd   = (phase == PH_RD);
  assign active   = cam_wr || cam_rd;
  assign beat_ack = active && cam_ack;

  always_comb begin
    cam_wdata = '0;
    if (phase == PH_WR_HI)      cam_wdata = key_q[KEY_W-1:BUS_W];
    else if (phase == PH_WR_LO) cam_wdata = key_q[BUS_W-1:0];
  end

  generate
    if (ACK_TIMEOUT > 0) begin : g_watchdog
      logic [CNT_W-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wait_q <= '0;
        else if (!active || cam_ack) wait_q <= '0;
        else                        wait_q <= wait_q + 1'b1;
      end
      assign beat_expire = active && !cam_ack && (wait_q == CNT_W'(ACK_TIMEOUT - 1));
    end else begin : g_no_watchdog
      assign beat_expire = 1'b0;
    end
  endgenerate

  // R1: never a write and a read on the same cycle
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cam_wr && cam_rd));

  // R2: an unacknowledged write stays on the bus unchanged
  a_r2_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_wr && !cam_ack && !beat_expire) |=> (cam_wr && $stable(cam_wdata)));

  // R2: an unacknowledged read stays on the bus
  a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cam_rd && !cam_ack && !beat_expire) |=> cam_rd);

endmodule

// File: rtl/cam_result_reg.sv
module cam_result_reg #(
  parameter int BUS_W = 32,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             rd_ack,
  input  logic             verdict_bit,
  input  logic [TAG_W-1:0] verdict_tag,
  input  logic             beat_expire,
  output logic             res_reject,
  output logic             res_tag_vld,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_timeout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_reject  <= 1'b0;
      res_tag_vld <= 1'b0;
      res_tag     <= '0;
      res_timeout <= 1'b0;
    end else if (req_fire) begin
      res_reject  <= 1'b0;
      res_tag_vld <= 1'b0;
      res_tag     <= '0;
      res_timeout <= 1'b0;
    end else if (rd_ack) begin
      res_reject  <= verdict_bit;
      res_tag_vld <= !verdict_bit;
      res_tag     <= verdict_bit ? '0 : verdict_tag;
    end else if (beat_expire) begin
      res_reject  <= 1'b1;
      res_tag_vld <= 1'b0;
      res_timeout <= 1'b1;
    end
  end

  // R3: a rejected frame never carries a tag
  a_r3_reject_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    res_reject |-> !res_tag_vld);

  // R4: an accepted verdict exposes its low half as the tag
  a_r4_tag_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !verdict_bit) |=> (res_tag_vld && res_tag == $past(verdict_tag)));

  // R8: a timeout is always reported as a rejection
  a_r8_timeout_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    res_timeout |-> res_reject);

endmodule

// File: rtl/cam_lookup_seq.sv
module cam_lookup_seq
  import cam_lookup_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int TAG_W       = 16,
  parameter int ACK_TIMEOUT = 16,
  localparam int KEY_W      = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             promisc_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [KEY_W-1:0] req_key,
  output logic             cam_wr,
  output logic             cam_rd,
  output logic [BUS_W-1:0] cam_wdata,
  input  logic [BUS_W-1:0] cam_rdata,
  input  logic             cam_ack,
  output logic             res_done,
  output logic             res_reject,
  output logic             res_tag_vld,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_timeout
);

  phase_t phase;
  logic   req_fire;
  logic   beat_ack;
  logic   beat_expire;
  logic   rd_ack;
  logic   unused_rdata_bits;

  assign rd_ack            = beat_ack && (phase == PH_RD);
  assign unused_rdata_bits = ^cam_rdata[BUS_W-2:TAG_W];

  cam_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .promisc_en  (promisc_en),
    .beat_ack    (beat_ack),
    .beat_expire (beat_expire),
    .phase       (phase),
    .req_ready   (req_ready),
    .req_fire    (req_fire),
    .res_done    (res_done)
  );

  cam_bus_master #(
    .BUS_W       (BUS_W),
    .ACK_TIMEOUT (ACK_TIMEOUT)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .req_fire    (req_fire),
    .req_key     (req_key),
    .cam_ack     (cam_ack),
    .cam_wr      (cam_wr),
    .cam_rd      (cam_rd),
    .cam_wdata   (cam_wdata),
    .beat_ack    (beat_ack),
    .beat_expire (beat_expire)
  );

  cam_result_reg #(
    .BUS_W (BUS_W),
    .TAG_W (TAG_W)
  ) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .rd_ack      (rd_ack),
    .verdict_bit (cam_rdata[BUS_W-1]),
    .verdict_tag (cam_rdata[TAG_W-1:0]),
    .beat_expire (beat_expire),
    .res_reject  (res_reject),
    .res_tag_vld (res_tag_vld),
    .res_tag     (res_tag),
    .res_timeout (res_timeout)
  );

  // R7: nothing is on the CAM bus while a request may be taken
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cam_wr && !cam_rd));

endmodule

// File: tb/cam_lookup_seq_tb.sv
module cam_lookup_seq_tb_top;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        promisc_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_key = '0;
  logic [31:0] cam_rdata = '0;
  logic        cam_ack = 1'b0;
  logic        req_ready, cam_wr, cam_rd, res_done, res_reject, res_tag_vld, res_timeout;
  logic [31:0] cam_wdata;
  logic [15:0] res_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int          mphase = 0;
  int          mwait = 0;
  logic [63:0] mkey = '0;
  logic        mrej = 0, mtagv = 0, mto = 0;
  logic [15:0] mtag = '0;

  // CAM responder controls
  int delays[3] = '{0, 0, 0};
  int bcnt = 0;
  bit stray_ack = 0;

  always #2 clk = ~clk;

  cam_lookup_seq #(.ACK_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .cam_wr(cam_wr), .cam_rd(cam_rd), .cam_wdata(cam_wdata),
    .cam_rdata(cam_rdata), .cam_ack(cam_ack),
    .res_done(res_done), .res_reject(res_reject), .res_tag_vld(res_tag_vld),
    .res_tag(res_tag), .res_timeout(res_timeout)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mphase = 0; mwait = 0; mrej = 0; mtagv = 0; mto = 0; mtag = '0;
    end else begin
      case (mphase)
        0: if (req_valid) begin
             mkey = req_key; mrej = 0; mtagv = 0; mto = 0; mtag = '0; mwait = 0;
             mphase = promisc_en ? 1 : 4;
           end
        1, 2, 3: begin
          if (cam_ack) begin
            if (mphase == 3) begin
              mrej  = cam_rdata[31];
              mtagv = !cam_rdata[31];
              mtag  = cam_rdata[31] ? 16'h0 : cam_rdata[15:0];
            end
            mphase = (mphase == 3) ? 4 : mphase + 1;
            mwait = 0;
          end else if (mwait == TMO - 1) begin
            mrej = 1; mto = 1; mphase = 4; mwait = 0;
          end else begin
            mwait++;
          end
        end
        default: mphase = 0;
      endcase
    end
  end

  // compare every cycle, then drive the CAM responder
  always @(negedge clk) begin
    if (!finished) begin
      string p;
      p = rst_n ? "" : "R9 ";
      chk({p, "R7 req_ready"}, 64'(req_ready), 64'(mphase == 0));
      chk({p, "R1 R2 R6 cam_wr"}, 64'(cam_wr), 64'(mphase == 1 || mphase == 2));
      chk({p, "R1 R2 R6 cam_rd"}, 64'(cam_rd), 64'(mphase == 3));
      if (cam_wr)
        chk("R1 R2 cam_wdata", 64'(cam_wdata), (mphase == 1) ? 64'(mkey[63:32]) : 64'(mkey[31:0]));
      chk({p, "R5 res_done"}, 64'(res_done), 64'(mphase == 4));
      chk({p, "R3 R8 res_reject"}, 64'(res_reject), 64'(mrej));
      chk({p, "R4 R6 res_tag_vld"}, 64'(res_tag_vld), 64'(mtagv));
      chk({p, "R3 R4 res_tag"}, 64'(res_tag), 64'(mtag));
      chk({p, "R8 res_timeout"}, 64'(res_timeout), 64'(mto));
    end
    if (rst_n && mphase >= 1 && mphase <= 3) begin
      if (delays[mphase-1] >= 0 && bcnt == delays[mphase-1]) begin
        cam_ack = 1'b1; bcnt = 0;
      end else begin
        cam_ack = 1'b0; bcnt++;
      end
    end else begin
      cam_ack = stray_ack; bcnt = 0;
    end
  end

  task automatic lookup(logic prom, logic [63:0] key, logic [31:0] verdict,
                        int d0, int d1, int d2, bit hold_noise);
    delays = '{d0, d1, d2};
    cam_rdata = verdict;
    do @(negedge clk); while (!req_ready);
    promisc_en = prom; req_key = key; req_valid = 1'b1;
    @(negedge clk);
    if (hold_noise) req_key = ~key;
    else req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);          // R9 reset values compared each cycle
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    lookup(1'b0, 64'h0123_4567_89AB_CDEF, 32'h0000_5555, 0, 0, 0, 0);   // R6 bypass
    lookup(1'b1, 64'hDEAD_BEEF_CAFE_F00D, 32'h1234_BEEF, 0, 0, 0, 0);   // R1 R4
    lookup(1'b1, 64'h1111_2222_3333_4444, 32'h8000_1234, 3, 1, 2, 0);   // R2 R3
    stray_ack = 1;                                                      // R7 idle acks
    repeat (4) @(negedge clk);
    stray_ack = 0;
    lookup(1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 32'h7FFF_0001, 2, 2, 2, 1);   // R7 busy hold
    lookup(1'b1, 64'h0000_0001_8000_0000, 32'h0000_FFFF, 7, 7, 7, 0);   // R8 last cycle ok
    lookup(1'b1, 64'hFFFF_FFFF_0000_0000, 32'h0000_1111, -1, 0, 0, 0);  // R8 write timeout
    lookup(1'b1, 64'h5555_AAAA_5555_AAAA, 32'h0000_2222, 0, 0, -1, 0);  // R8 read timeout
    lookup(1'b1, 64'h0F0F_0F0F_1234_5678, 32'hFFFF_ABCD, 1, 0, 4, 0);   // R3
    lookup(1'b0, 64'h7777_8888_9999_AAAA, 32'h0000_3333, 0, 0, 0, 0);   // R6 again
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule